// File: doc/BRIEF.md
# Queued SPI Master with Per-Entry Command Words

This block is a memory-mapped SPI master that shifts a queue of up to sixteen bytes on its own, without software handling each byte. Software fills a transmit memory with data bytes and a command memory with one command word per queue entry. It then writes a first-entry pointer and a last-entry pointer and sets the run bit. The engine walks the entries in ascending order and shifts each byte out in mode 0. Each entry drives its own active-low chip-select mask, and each received byte is stored in a receive memory.

When the last entry is finished, the engine sets a sticky done flag and clears the run bit in the same cycle. Each command word chooses whether chip select stays asserted into the following entry, and whether an added lead-in delay comes before the first clock edge. A hold bit in the control register, or the lock register, keeps chip select asserted after the queue ends, so the next queue run can continue the same flash transaction.

The register bus is a plain 32-bit interface. Writes are taken on the clock edge when `busWrEn` is high. Reads are combinational from `busAddr`. Each register is decoded by word address (`busAddr[9:2]`).

Top module: `spi_queue_master`

## Requirements
- R1: After reset, `sck` is 0, `csN` is 4'hF, `lockOut` is 0, and the control (0x218) and status (0x220) registers read 0. The divider register (0x200) reads 2, and `sck` stays low whenever the run bit is clear.
- R2: Writing 1 to control bit 6 (run) shifts the entries from the first pointer (0x210) up to the last pointer (0x214) inclusive, in ascending order. The byte for entry i comes from transmit word 0x240+8*i. It is sent MSB first on `mosi`, and `mosi` is stable while `sck` is high (mode 0: launch on the falling edge, sample on the rising edge).
- R3: The byte sampled from `miso` for entry i is readable at receive word 0x2C0+8*i+4. Receive words at 0x2C0+8*i read 0.
- R4: While an entry is being shifted, `csN` equals bits 3:0 of that entry's command word (0x340+4*i). A 0 bit asserts that line, and `csN` does not change while `sck` is high.
- R5: When an entry that is not the last has command bit 7 set, `csN` moves directly to the next entry's mask. When bit 7 is clear, `csN` returns to 4'hF for at least one half period before the next entry.
- R6: When the last entry ends, status bit 0 (done) is set and control bit 6 reads 0. Done stays set until software writes status with bit 0 = 0.
- R7: After the last entry, `csN` keeps that entry's mask if control bit 7 (hold) or the lock bit is set. Otherwise `csN` returns to 4'hF.
- R8: Lock register bit 0 (0x380) appears on `lockOut`. Writing 0 to it while no run is active releases a held chip select (`csN` becomes 4'hF).
- R9: While the run bit is set, writes to the pointer registers, the transmit memory and the command memory have no effect.
- R10: An `sck` half period lasts N system clocks, where N is the divider value; a divider of 0 acts as 1. Successive rising edges are therefore 2*N clocks apart.
- R11: From `csN` leaving 4'hF to the first rising `sck` edge takes N clocks. When command bit 4 is set, it takes (DLY_HALVES+1)*N clocks (DLY_HALVES defaults to 4).
- R12: The current-entry register (0x224) reads the index of the entry being shifted. After a run it reads the last pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 10 | Byte address of the register access |
| busWrData | input | 32 | Register write data |
| busRdData | output | 32 | Register read data (combinational) |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csN | output | 4 | Active-low chip selects |
| lockOut | output | 1 | Lock bit as written by software |

## Verification
A register write takes effect at the clock edge that samples it, so the bench reads registers back at the next falling edge. Chip select changes one clock after an entry is loaded. The first rising `sck` edge follows N clocks later, or (DLY_HALVES+1)*N clocks later with the delay bit set. The bench measures these spacings from the time stamps of `csN` and `sck` transitions and compares them with multiples of the clock period. Done and the cleared run bit appear at the edge of the final falling `sck` edge, so the bench polls the status register until done is set and only then reads the receive memory, pointers and current entry.

// File: rtl/spi_queue_pkg.sv
package spi_queue_pkg;
  // Word indices (byte address >> 2) of the register map
  localparam int WI_DIV    = 'h80;
  localparam int WI_QSTART = 'h84;
  localparam int WI_QEND   = 'h85;
  localparam int WI_CTL    = 'h86;
  localparam int WI_STAT   = 'h88;
  localparam int WI_CUR    = 'h89;
  localparam int WI_TX     = 'h90;
  localparam int WI_RX     = 'hB0;
  localparam int WI_CMD    = 'hD0;
  localparam int WI_LOCK   = 'hE0;
  localparam int SLOT_MAX  = 32;

  // Bit positions
  localparam int CTL_RUN  = 6;
  localparam int CTL_HOLD = 7;
  localparam int CMD_DLY  = 4;
  localparam int CMD_CONT = 7;

  // Control-to-datapath strobes
  typedef struct packed {
    logic loadEntry;
    logic riseEdge;
    logic fallEdge;
    logic storeRx;
    logic releaseCs;
    logic finish;
  } strobe_t;
endpackage

// File: rtl/spi_queue_dp.sv
module spi_queue_dp
  import spi_queue_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int DIV_W = 8,
  parameter int PTR_W = 4,
  parameter int DIV_RESET = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWrEn,
  input  logic [9:0]       busAddr,
  input  logic [31:0]      busWrData,
  output logic [31:0]      busRdData,
  input  strobe_t          stb,
  input  logic [PTR_W-1:0] curPtr,
  input  logic             miso,
  output logic             sck,
  output logic             mosi,
  output logic [3:0]       csN,
  output logic             lockOut,
  output logic             runBit,
  output logic             doneFlag,
  output logic [PTR_W-1:0] qStart,
  output logic [PTR_W-1:0] qEnd,
  output logic [7:0]       curCmd,
  output logic [DIV_W-1:0] divVal
);
  logic [7:0] txRam [ENTRIES];
  logic [7:0] rxRam [ENTRIES];
  logic [7:0] cmdRam [ENTRIES];
  logic [7:0] txSh, rxSh;
  logic [3:0] csReg;
  logic holdAfter, lockReg, wrOk;
  logic inTx, inRx, inCmd;
  int wIdx, txSlot, rxSlot, cmdSlot;
  logic [PTR_W-1:0] txEnt, rxEnt, cmdEnt;

  // Address decode: entry i owns even transmit slot 2i and odd receive slot 2i+1
  always_comb begin
    wIdx    = int'(busAddr[9:2]);
    txSlot  = wIdx - WI_TX;
    rxSlot  = wIdx - WI_RX;
    cmdSlot = wIdx - WI_CMD;
    inTx  = (wIdx >= WI_TX) && (txSlot < SLOT_MAX) && !txSlot[0] && ((txSlot >> 1) < ENTRIES);
    inRx  = (wIdx >= WI_RX) && (rxSlot < SLOT_MAX) && rxSlot[0] && ((rxSlot >> 1) < ENTRIES);
    inCmd = (wIdx >= WI_CMD) && (cmdSlot < ENTRIES) && (cmdSlot < SLOT_MAX / 2);
    txEnt  = PTR_W'(txSlot >> 1);
    rxEnt  = PTR_W'(rxSlot >> 1);
    cmdEnt = PTR_W'(cmdSlot);
    wrOk   = busWrEn && !runBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divVal <= DIV_W'(DIV_RESET);
      qStart <= '0;
      qEnd <= '0;
      runBit <= 1'b0;
      holdAfter <= 1'b0;
      doneFlag <= 1'b0;
      lockReg <= 1'b0;
      csReg <= 4'hF;
      sck <= 1'b0;
      txSh <= '0;
      rxSh <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        txRam[i] <= '0;
        rxRam[i] <= '0;
        cmdRam[i] <= '0;
      end
    end else begin
      if (wrOk) begin
        if (wIdx == WI_DIV) divVal <= busWrData[DIV_W-1:0];
        if (wIdx == WI_QSTART) qStart <= busWrData[PTR_W-1:0];
        if (wIdx == WI_QEND) qEnd <= busWrData[PTR_W-1:0];
        if (wIdx == WI_CTL) begin
          runBit <= busWrData[CTL_RUN];
          holdAfter <= busWrData[CTL_HOLD];
        end
        if (inTx) txRam[txEnt] <= busWrData[7:0];
        if (inCmd) cmdRam[cmdEnt] <= busWrData[7:0];
      end
      if (busWrEn && wIdx == WI_STAT && !busWrData[0]) doneFlag <= 1'b0;
      if (busWrEn && wIdx == WI_LOCK) begin
        lockReg <= busWrData[0];
        if (!busWrData[0] && !runBit) csReg <= 4'hF;
      end
      if (stb.loadEntry) begin
        txSh <= txRam[curPtr];
        csReg <= cmdRam[curPtr][3:0];
      end
      if (stb.riseEdge) begin
        sck <= 1'b1;
        rxSh <= {rxSh[6:0], miso};
      end
      if (stb.fallEdge) begin
        sck <= 1'b0;
        txSh <= {txSh[6:0], 1'b0};
      end
      if (stb.storeRx) rxRam[curPtr] <= rxSh;
      if (stb.releaseCs) csReg <= 4'hF;
      if (stb.finish) begin
        runBit <= 1'b0;
        doneFlag <= 1'b1;
        if (!(holdAfter || lockReg)) csReg <= 4'hF;
      end
    end
  end

  assign mosi = txSh[7];
  assign csN = csReg;
  assign lockOut = lockReg;
  assign curCmd = cmdRam[curPtr];

  always_comb begin
    busRdData = '0;
    if (wIdx == WI_DIV) busRdData = 32'(divVal);
    else if (wIdx == WI_QSTART) busRdData = 32'(qStart);
    else if (wIdx == WI_QEND) busRdData = 32'(qEnd);
    else if (wIdx == WI_CTL) busRdData = {24'd0, holdAfter, runBit, 6'd0};
    else if (wIdx == WI_STAT) busRdData = {31'd0, doneFlag};
    else if (wIdx == WI_CUR) busRdData = 32'(curPtr);
    else if (wIdx == WI_LOCK) busRdData = {31'd0, lockReg};
    else if (inTx) busRdData = {24'd0, txRam[txEnt]};
    else if (inRx) busRdData = {24'd0, rxRam[rxEnt]};
    else if (inCmd) busRdData = {24'd0, cmdRam[cmdEnt]};
  end
endmodule

// File: rtl/spi_queue_ctrl.sv
module spi_queue_ctrl
  import spi_queue_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int PTR_W = 4,
  parameter int DLY_HALVES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runBit,
  input  logic [PTR_W-1:0] qStart,
  input  logic [PTR_W-1:0] qEnd,
  input  logic [7:0]       curCmd,
  input  logic [DIV_W-1:0] divVal,
  output strobe_t          stb,
  output logic [PTR_W-1:0] curPtr
);
  localparam int LEAD_W = $clog2(DLY_HALVES + 2);

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_LEAD, S_HIGH, S_LOW, S_GAP} state_t;
  state_t state;
  logic [DIV_W-1:0] cnt, divM1;
  logic [LEAD_W-1:0] lead;
  logic [2:0] bitCnt;
  logic tick, lastBit, lastEntry;

  assign divM1 = (divVal == '0) ? '0 : divVal - 1'b1;
  assign tick = (cnt == '0);
  assign lastBit = (bitCnt == 3'd7);
  assign lastEntry = (curPtr == qEnd);

  always_comb begin
    stb = '0;
    case (state)
      S_LOAD: stb.loadEntry = 1'b1;
      S_LEAD: stb.riseEdge = tick && (lead == '0);
      S_LOW:  stb.riseEdge = tick;
      S_HIGH: if (tick) begin
        stb.fallEdge = 1'b1;
        if (lastBit) begin
          stb.storeRx = 1'b1;
          stb.finish = lastEntry;
          stb.releaseCs = !lastEntry && !curCmd[CMD_CONT];
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      curPtr <= '0;
      cnt <= '0;
      lead <= '0;
      bitCnt <= '0;
    end else begin
      if (state != S_IDLE && state != S_LOAD) cnt <= tick ? divM1 : cnt - 1'b1;
      case (state)
        S_IDLE: if (runBit) begin
          curPtr <= qStart;
          state <= S_LOAD;
        end
        S_LOAD: begin
          cnt <= divM1;
          lead <= curCmd[CMD_DLY] ? LEAD_W'(DLY_HALVES) : '0;
          state <= S_LEAD;
        end
        S_LEAD: if (tick) begin
          if (lead == '0) begin
            bitCnt <= '0;
            state <= S_HIGH;
          end else lead <= lead - 1'b1;
        end
        S_LOW: if (tick) state <= S_HIGH;
        S_HIGH: if (tick) begin
          if (!lastBit) begin
            bitCnt <= bitCnt + 1'b1;
            state <= S_LOW;
          end else if (lastEntry) state <= S_IDLE;
          else if (curCmd[CMD_CONT]) begin
            curPtr <= curPtr + 1'b1;
            state <= S_LOAD;
          end else state <= S_GAP;
        end
        S_GAP: if (tick) begin
          curPtr <= curPtr + 1'b1;
          state <= S_LOAD;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_queue_master.sv
module spi_queue_master
  import spi_queue_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int DIV_W = 8,
  parameter int DIV_RESET = 2,
  parameter int DLY_HALVES = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWrEn,
  input  logic [9:0]  busAddr,
  input  logic [31:0] busWrData,
  output logic [31:0] busRdData,
  output logic        sck,
  output logic        mosi,
  input  logic        miso,
  output logic [3:0]  csN,
  output logic        lockOut
);
  localparam int PTR_W = $clog2(ENTRIES);

  strobe_t stb;
  logic [PTR_W-1:0] curPtr, qStart, qEnd;
  logic [7:0] curCmd;
  logic [DIV_W-1:0] divVal;
  logic runBit, doneFlag;

  spi_queue_dp #(.ENTRIES(ENTRIES), .DIV_W(DIV_W), .PTR_W(PTR_W), .DIV_RESET(DIV_RESET)) u_dp (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr), .busWrData(busWrData),
    .busRdData(busRdData), .stb(stb), .curPtr(curPtr), .miso(miso), .sck(sck), .mosi(mosi),
    .csN(csN), .lockOut(lockOut), .runBit(runBit), .doneFlag(doneFlag), .qStart(qStart),
    .qEnd(qEnd), .curCmd(curCmd), .divVal(divVal)
  );

  spi_queue_ctrl #(.DIV_W(DIV_W), .PTR_W(PTR_W), .DLY_HALVES(DLY_HALVES)) u_ctrl (
    .clk(clk), .rstN(rstN), .runBit(runBit), .qStart(qStart), .qEnd(qEnd),
    .curCmd(curCmd), .divVal(divVal), .stb(stb), .curPtr(curPtr)
  );
endmodule

// File: rtl/spi_queue_chk.sv
module spi_queue_chk
  import spi_queue_pkg::*;
#(
  parameter int PTR_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             busWrEn,
  input logic [9:0]       busAddr,
  input logic [31:0]      busWrData,
  input logic             sck,
  input logic             mosi,
  input logic [3:0]       csN,
  input logic             runBit,
  input logic             doneFlag,
  input logic [PTR_W-1:0] qStart,
  input logic [PTR_W-1:0] qEnd
);
  p_idle_sck_low_r1: assert property (@(posedge clk) disable iff (!rstN)
    !runBit |-> !sck);

  p_mosi_stable_high_r2: assert property (@(posedge clk) disable iff (!rstN)
    sck |-> $stable(mosi));

  p_cs_stable_high_r4: assert property (@(posedge clk) disable iff (!rstN)
    sck |-> $stable(csN));

  p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    (doneFlag && !(busWrEn && int'(busAddr[9:2]) == WI_STAT && !busWrData[0])) |=> doneFlag);

  p_run_end_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(runBit) |-> doneFlag);

  p_ptr_frozen_r9: assert property (@(posedge clk) disable iff (!rstN)
    runBit |=> ($stable(qStart) && $stable(qEnd)));
endmodule

bind spi_queue_master spi_queue_chk #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr), .busWrData(busWrData),
  .sck(sck), .mosi(mosi), .csN(csN), .runBit(runBit), .doneFlag(doneFlag),
  .qStart(qStart), .qEnd(qEnd)
);

// File: tb/spi_queue_master_tb.sv
module spi_queue_master_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DLY = 4;
  localparam logic [9:0] A_DIV = 10'h200, A_QSTART = 10'h210, A_QEND = 10'h214,
    A_CTL = 10'h218, A_STAT = 10'h220, A_CUR = 10'h224, A_TX = 10'h240,
    A_RX = 10'h2C0, A_CMD = 10'h340, A_LOCK = 10'h380;

  logic clk = 1'b0, rstN = 1'b0, busWrEn = 1'b0, miso = 1'b0;
  logic [9:0] busAddr = '0;
  logic [31:0] busWrData = '0, busRdData;
  logic sck, mosi, lockOut;
  logic [3:0] csN;
  int nChecks = 0, nFail = 0;

  spi_queue_master #(.DLY_HALVES(DLY)) u_dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr), .busWrData(busWrData),
    .busRdData(busRdData), .sck(sck), .mosi(mosi), .miso(miso), .csN(csN), .lockOut(lockOut)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // ---- serial slave model and edge monitor ----
  logic [7:0] capByte [256];
  logic [3:0] capCs [256];
  logic [7:0] shIn = '0;
  int byteCount = 0, bitIdx = 0, csEpoch = 0, seenEpoch = 0, riseIdx = 0, relCount = 0;
  time csAssertT = 0, riseT1 = 0, riseT2 = 0;
  logic [3:0] prevCs = 4'hF;

  function automatic logic [7:0] respByte(int n);
    return 8'((n * 29 + 60) & 255);
  endfunction

  always @(csN) begin
    if (prevCs == 4'hF && csN != 4'hF) begin
      csEpoch++;
      csAssertT = $time;
    end
    if (csN == 4'hF && prevCs != 4'hF) relCount++;
    prevCs = csN;
  end

  always @(posedge sck) begin
    logic [7:0] r;
    if (seenEpoch != csEpoch) begin
      seenEpoch = csEpoch;
      riseT1 = $time;
      riseIdx = 1;
    end else if (riseIdx == 1) begin
      riseT2 = $time;
      riseIdx = 2;
    end
    shIn = {shIn[6:0], mosi};
    bitIdx++;
    if (bitIdx == 8) begin
      capByte[byteCount & 255] = shIn;
      capCs[byteCount & 255] = csN;
      byteCount++;
      bitIdx = 0;
    end
    r = respByte(byteCount);
    miso = r[7 - bitIdx];
  end

  // ---- helpers ----
  task automatic check(string req, string what, longint act, longint exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic busWrite(logic [9:0] a, logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(logic [9:0] a, output logic [31:0] v);
    @(negedge clk);
    busAddr = a;
    #1 v = busRdData;
  endtask

  function automatic logic [9:0] txA(int i); return A_TX + 10'(8 * i); endfunction
  function automatic logic [9:0] rxA(int i); return A_RX + 10'(8 * i + 4); endfunction
  function automatic logic [9:0] cmdA(int i); return A_CMD + 10'(4 * i); endfunction

  task automatic startQueue(int qs, int qe, logic hold);
    busWrite(A_QSTART, 32'(qs));
    busWrite(A_QEND, 32'(qe));
    busWrite(A_CTL, 32'h40 | (32'(hold) << 7));
  endtask

  task automatic waitDone();
    logic [31:0] v = 0;
    int n = 0;
    while (!v[0] && n < 20000) begin
      busRead(A_STAT, v);
      n++;
    end
    check("R6", "done flag within poll budget", v[0], 1);
  endtask

  // ---- scenarios ----
  task automatic t_reset();
    logic [31:0] v;
    check("R1", "sck after reset", sck, 0);
    check("R1", "csN after reset", csN, 4'hF);
    check("R1", "lockOut after reset", lockOut, 0);
    busRead(A_CTL, v);  check("R1", "control after reset", v, 0);
    busRead(A_STAT, v); check("R1", "status after reset", v, 0);
    busRead(A_DIV, v);  check("R1", "divider after reset", v, 2);
  endtask

  task automatic t_basic();
    logic [31:0] v;
    int sb, rel0;
    for (int i = 0; i < 4; i++) begin
      busWrite(txA(i), 32'h81 + 32'(i * 17));
      busWrite(cmdA(i), (i < 3) ? 32'h8E : 32'h0E);
    end
    sb = byteCount; rel0 = relCount;
    startQueue(0, 3, 1'b0);
    waitDone();
    check("R2", "bytes shifted", byteCount - sb, 4);
    for (int i = 0; i < 4; i++) begin
      check("R2", "mosi byte", capByte[(sb + i) & 255], 8'h81 + 8'(i * 17));
      check("R4", "csN during entry", capCs[(sb + i) & 255], 4'hE);
      busRead(rxA(i), v);
      check("R3", "received byte in odd slot", v, respByte(sb + i));
    end
    busRead(A_RX, v); check("R3", "even receive slot reads 0", v, 0);
    check("R5", "cs released once for chained entries", relCount - rel0, 1);
    check("R7", "csN after run without hold", csN, 4'hF);
    busRead(A_CTL, v); check("R6", "run bit cleared", v[6], 0);
    busRead(A_CUR, v); check("R12", "current entry after run", v, 3);
    busRead(A_STAT, v); check("R6", "done stays set", v[0], 1);
    busWrite(A_STAT, 0);
    busRead(A_STAT, v); check("R6", "done cleared by writing 0", v[0], 0);
  endtask

  task automatic t_gap();
    int sb, rel0;
    logic [3:0] m [3] = '{4'hD, 4'hB, 4'h7};
    for (int i = 0; i < 3; i++) begin
      busWrite(txA(4 + i), 32'h10 + 32'(i));
      busWrite(cmdA(4 + i), 32'(m[i]));
    end
    sb = byteCount; rel0 = relCount;
    startQueue(4, 6, 1'b0);
    waitDone();
    busWrite(A_STAT, 0);
    for (int i = 0; i < 3; i++) begin
      check("R2", "ascending entry order", capByte[(sb + i) & 255], 8'h10 + 8'(i));
      check("R4", "per-entry mask", capCs[(sb + i) & 255], m[i]);
    end
    check("R5", "release after each entry without chain bit", relCount - rel0, 3);
  endtask

  task automatic t_hold();
    int rel0;
    busWrite(txA(7), 32'h6D);
    busWrite(cmdA(7), 32'h0B);
    startQueue(7, 7, 1'b1);
    waitDone();
    busWrite(A_STAT, 0);
    check("R7", "csN held after run with hold bit", csN, 4'hB);
    rel0 = relCount;
    startQueue(7, 7, 1'b0);
    waitDone();
    busWrite(A_STAT, 0);
    check("R7", "csN released after run without hold", csN, 4'hF);
    check("R7", "one release in second run", relCount - rel0, 1);
  endtask

  task automatic t_lock();
    busWrite(A_LOCK, 1);
    check("R8", "lockOut follows lock bit", lockOut, 1);
    startQueue(7, 7, 1'b0);
    waitDone();
    busWrite(A_STAT, 0);
    check("R7", "csN held by lock", csN, 4'hB);
    busWrite(A_LOCK, 0);
    check("R8", "lockOut cleared", lockOut, 0);
    check("R8", "lock clear releases chip select", csN, 4'hF);
  endtask

  task automatic t_ignore();
    logic [31:0] v;
    int sb;
    busWrite(A_DIV, 6);
    busWrite(txA(8), 32'hC3); busWrite(txA(9), 32'h3C); busWrite(txA(10), 32'h99);
    busWrite(cmdA(8), 32'h8E); busWrite(cmdA(9), 32'h8E); busWrite(cmdA(10), 32'h0E);
    sb = byteCount;
    startQueue(8, 10, 1'b0);
    busWrite(A_QSTART, 1); busWrite(A_QEND, 2);
    busWrite(txA(8), 32'hFF); busWrite(cmdA(8), 32'h00);
    busRead(A_CUR, v); check("R12", "current entry during run", v, 8);
    waitDone();
    busWrite(A_STAT, 0);
    busRead(A_QSTART, v); check("R9", "first pointer unchanged", v, 8);
    busRead(A_QEND, v);   check("R9", "last pointer unchanged", v, 10);
    busRead(txA(8), v);   check("R9", "transmit byte unchanged", v, 32'hC3);
    busRead(cmdA(8), v);  check("R9", "command word unchanged", v, 32'h8E);
    check("R9", "bytes shifted", byteCount - sb, 3);
    check("R2", "entry 8 byte", capByte[sb & 255], 8'hC3);
    check("R2", "entry 10 byte", capByte[(sb + 2) & 255], 8'h99);
  endtask

  task automatic t_timing();
    busWrite(txA(12), 32'h5A); busWrite(cmdA(12), 32'h0E);
    busWrite(txA(13), 32'hA5); busWrite(cmdA(13), 32'h1E);
    busWrite(A_DIV, 3);
    startQueue(12, 12, 1'b0); waitDone(); busWrite(A_STAT, 0);
    check("R11", "cs to first rise, no delay (clocks)", (riseT1 - csAssertT) / CLK_PERIOD, 3);
    check("R10", "rise to rise, divider 3 (clocks)", (riseT2 - riseT1) / CLK_PERIOD, 6);
    startQueue(13, 13, 1'b0); waitDone(); busWrite(A_STAT, 0);
    check("R11", "cs to first rise with delay bit (clocks)", (riseT1 - csAssertT) / CLK_PERIOD, (DLY + 1) * 3);
    busWrite(A_DIV, 0);
    startQueue(12, 12, 1'b0); waitDone(); busWrite(A_STAT, 0);
    check("R10", "rise to rise, divider 0 (clocks)", (riseT2 - riseT1) / CLK_PERIOD, 2);
    check("R11", "cs to first rise, divider 0 (clocks)", (riseT1 - csAssertT) / CLK_PERIOD, 1);
  endtask

  initial begin
    miso = respByte(0)[7];
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_gap();
    t_hold();
    t_lock();
    t_ignore();
    t_timing();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule